// File: doc/BRIEF.md
# Bit-banged serial EEPROM slave

This block models a small read-only serial EEPROM that answers on a two-wire bus whose clock and data lines are moved by software. A register-driven master changes its clock and data levels one write at a time; each write pulses `line_upd` for one cycle together with the new `scl_in` and `sda_in` levels. The block reacts only on those pulses, so it needs no timing relation between the bus and the system clock. Its storage holds 128 or 256 bytes set by a parameter image. The default image puts the byte `(7*i + 3) mod 256` at index `i`, a stand-in for a memory-module presence-detect table.

A transaction starts with a START condition and carries a command byte, an acknowledge, an address byte and a second acknowledge. At the end of the address byte the slave fetches the addressed byte into a data shift register. That byte is shifted out, most significant bit first, during the address phase of the *next* read transaction. The controller runs five states. `ST_IDLE` waits for START. `ST_CMD` collects command bits. `ST_CMD_ACK` waits for the acknowledge slot of the command. `ST_ADDR` collects address bits and, for reads, shifts data out. `ST_ADDR_ACK` waits for the final acknowledge slot. The transitions are:

- START from any state goes to `ST_CMD`.
- STOP from any state goes to `ST_IDLE`.
- The eighth command bit goes from `ST_CMD` to `ST_CMD_ACK`.
- The acknowledge edge goes from `ST_CMD_ACK` to `ST_ADDR`.
- The eighth address bit goes from `ST_ADDR` to `ST_ADDR_ACK`.
- The acknowledge edge goes from `ST_ADDR_ACK` back to `ST_IDLE`.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After synchronous reset `sda_out` is 1 (released) and the controller is idle.
- R2: While idle, rising clock updates are ignored: nine data pulses without a preceding START never pull `sda_out` low.
- R3: An update with the clock high in both the previous and the current update, where SDA falls from 1 to 0, is START. It clears the command register and starts counting command bits, so the ninth rising clock after it is an acknowledge.
- R4: On an acknowledge edge `sda_out` goes to 0 for exactly that update. The next update of any kind releases it to 1.
- R5: A data bit is taken only on a rising clock update whose SDA equals the SDA of the previous update. A rising clock with changed SDA is not counted.
- R6: After eight address bits, the next rising clock is acknowledged (R4 behaviour) and the controller returns to idle.
- R7: When the command's last bit is 1 (read), each counted address bit makes the slave drive bit 7 of the data register onto `sda_out`, after which the register shifts left. The data register holds the byte fetched at the end of the previous address phase, and 0 after reset.
- R8: The stored byte is selected by the address modulo the capacity `DEPTH`.
- R9: An update with the clock high in both updates, where SDA rises from 0 to 1, is STOP and returns the controller to idle from any phase.
- R10: A START in the middle of a transaction restarts the command phase from its first bit.
- R11: Level changes on `scl_in` and `sda_in` without `line_upd` have no effect on state or on `sda_out`.
- R12: Reset in the middle of a transaction returns to idle and clears the data register, while the stored image is unchanged.
- R13: When the command's last bit is 0 (write), `sda_out` stays 1 through the address bits; both acknowledges still occur and the fetch still happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_upd | input | 1 | One-cycle strobe: a new bus level pair is presented |
| scl_in | input | 1 | Clock level written by the master |
| sda_in | input | 1 | Data level written by the master |
| sda_out | output | 1 | Data level driven by the slave, 1 when released |

## Verification
The bench builds the slave with `DEPTH` set to 128 and the default image. With that capacity, an 8-bit address above 127 must wrap to a lower byte, which checks the modulo selection directly. The smaller capacity also puts the top byte, index 127, within reach for the edge-of-array read. Because the read data lags by one transaction, the bench chains reads and a write. Each transaction's output then proves the previous transaction's fetch, including the fetch made during a write.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

    localparam int IMG_BYTES     = 256;
    localparam int BITS_PER_BYTE = 8;
    localparam int BIT_CNT_W     = $clog2(BITS_PER_BYTE);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_CMD_ACK,
        ST_ADDR,
        ST_ADDR_ACK
    } xfer_state_t;

    // Default contents: byte i holds (7*i + 3) mod 256.
    function automatic logic [IMG_BYTES*8-1:0] default_image();
        logic [IMG_BYTES*8-1:0] img;
        for (int i = 0; i < IMG_BYTES; i++) begin
            img[i*8 +: 8] = 8'((i * 7) + 3);
        end
        return img;
    endfunction

endpackage

// File: rtl/eeprom_bus_sampler.sv
module eeprom_bus_sampler (
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic stable_o
);

    logic scl_prev_q;
    logic sda_prev_q;
    logic clk_held_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else if (upd) begin
            scl_prev_q <= scl_in;
            sda_prev_q <= sda_in;
        end
    end

    assign clk_held_high = scl_prev_q & scl_in;
    assign start_o  = clk_held_high &  sda_prev_q & ~sda_in;
    assign stop_o   = clk_held_high & ~sda_prev_q &  sda_in;
    assign rise_o   = ~scl_prev_q & scl_in;
    assign stable_o = (sda_prev_q == sda_in);

    // R11: sampled history only advances on a strobe
    p_history_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        !upd |=> ($stable(scl_prev_q) && $stable(sda_prev_q)));

endmodule

// File: rtl/eeprom_image_rom.sv
module eeprom_image_rom #(
    parameter int DEPTH = 256,
    parameter logic [eeprom_i2c_pkg::IMG_BYTES*8-1:0] IMAGE = eeprom_i2c_pkg::default_image()
) (
    input  logic [7:0] idx,
    output logic [7:0] q
);

    localparam int SLOT_W = $clog2(eeprom_i2c_pkg::IMG_BYTES);

    logic [SLOT_W-1:0] slot;

    // R8: address folds onto the configured capacity
    assign slot = SLOT_W'(int'(idx) % DEPTH);
    assign q    = IMAGE[slot*8 +: 8];

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
    parameter int DEPTH = 256,
    parameter logic [eeprom_i2c_pkg::IMG_BYTES*8-1:0] IMAGE = eeprom_i2c_pkg::default_image()
) (
    input  logic clk,
    input  logic rst,
    input  logic line_upd,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_out
);
    import eeprom_i2c_pkg::*;

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BITS_PER_BYTE - 1);

    xfer_state_t          state_q, state_n;
    logic [BIT_CNT_W-1:0] cnt_q, cnt_n;
    logic [7:0]           cmd_q, cmd_n;
    logic [7:0]           addr_q, addr_n;
    logic [7:0]           data_q, data_n;
    logic                 drv_q, drv_n;

    logic                 is_start, is_stop, is_rise, is_stable;
    logic [7:0]           addr_shift;
    logic [7:0]           rom_q;

    eeprom_bus_sampler u_sampler (
        .clk      (clk),
        .rst      (rst),
        .upd      (line_upd),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .start_o  (is_start),
        .stop_o   (is_stop),
        .rise_o   (is_rise),
        .stable_o (is_stable)
    );

    assign addr_shift = (addr_q << 1) | {7'd0, sda_in};

    eeprom_image_rom #(
        .DEPTH (DEPTH),
        .IMAGE (IMAGE)
    ) u_rom (
        .idx (addr_shift),
        .q   (rom_q)
    );

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        cmd_n   = cmd_q;
        addr_n  = addr_q;
        data_n  = data_q;
        drv_n   = drv_q;
        if (line_upd) begin
            drv_n = 1'b1;
            if (is_start) begin
                state_n = ST_CMD;
                cnt_n   = '0;
                cmd_n   = '0;
            end else if (is_stop) begin
                state_n = ST_IDLE;
            end else if (is_rise) begin
                unique case (state_q)
                    ST_IDLE: begin
                    end
                    ST_CMD: begin
                        if (is_stable) begin
                            cmd_n = (cmd_q << 1) | {7'd0, sda_in};
                            if (cnt_q == LAST_BIT) begin
                                state_n = ST_CMD_ACK;
                                cnt_n   = '0;
                            end else begin
                                cnt_n = cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_CMD_ACK: begin
                        drv_n   = 1'b0;
                        state_n = ST_ADDR;
                    end
                    ST_ADDR: begin
                        if (is_stable) begin
                            if (cmd_q[0]) begin
                                drv_n = data_q[7];
                            end
                            addr_n = addr_shift;
                            data_n = data_q << 1;
                            if (cnt_q == LAST_BIT) begin
                                data_n  = rom_q;
                                state_n = ST_ADDR_ACK;
                                cnt_n   = '0;
                            end else begin
                                cnt_n = cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        drv_n   = 1'b0;
                        state_n = ST_IDLE;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cmd_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            cmd_q   <= cmd_n;
            addr_q  <= addr_n;
            data_q  <= data_n;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= 1'b1;
        end else begin
            drv_q <= drv_n;
        end
    end

    assign sda_out = drv_q;

    // R11: nothing moves between strobes
    p_hold_between_strobes_r11: assert property (@(posedge clk) disable iff (rst)
        !line_upd |=> ($stable(state_q) && $stable(sda_out) && $stable(data_q)));

    // R3: a START always lands in the first command bit
    p_start_enters_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        (line_upd && is_start) |=> (state_q == ST_CMD && cnt_q == '0 && cmd_q == '0));

    // R9: a STOP always lands in idle
    p_stop_goes_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (line_upd && is_stop) |=> (state_q == ST_IDLE));

    // R4: the command acknowledge slot pulls the line low
    p_cmd_ack_low_r4: assert property (@(posedge clk) disable iff (rst)
        (line_upd && state_q == ST_CMD_ACK && is_rise && !is_start && !is_stop)
        |=> (!sda_out && state_q == ST_ADDR));

    // R2: idle ignores everything but START
    p_idle_released_r2: assert property (@(posedge clk) disable iff (rst)
        (line_upd && state_q == ST_IDLE && !is_start) |=> (state_q == ST_IDLE && sda_out));

    // R13: a write command never drives data bits
    p_write_silent_r13: assert property (@(posedge clk) disable iff (rst)
        (line_upd && state_q == ST_ADDR && !cmd_q[0]) |=> sda_out);

endmodule

// File: tb/test_i2c_eeprom_slave.sv
module test_i2c_eeprom_slave;

    localparam int DEPTH = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_upd = 1'b0;
    logic scl_i = 1'b1;
    logic sda_i = 1'b1;
    logic sda_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    i2c_eeprom_slave #(.DEPTH(DEPTH)) i_i2c_eeprom_slave (
        .clk      (clk),
        .rst      (rst),
        .line_upd (line_upd),
        .scl_in   (scl_i),
        .sda_in   (sda_i),
        .sda_out  (sda_o)
    );

    // {command, address, expected read-out bits, tag: 0=R7 1=R8 2=R13}
    localparam logic [25:0] VEC [5] = '{
        {8'hA1, 8'h03, 8'h00, 2'd0},
        {8'hA1, 8'h85, 8'h18, 2'd0},
        {8'hA1, 8'h10, 8'h26, 2'd1},
        {8'hA0, 8'h7F, 8'h00, 2'd2},
        {8'hA1, 8'h00, 8'h7C, 2'd0}
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic d, output logic q);
        @(negedge clk);
        scl_i = c;
        sda_i = d;
        line_upd = 1'b1;
        @(negedge clk);
        line_upd = 1'b0;
        q = sda_o;
    endtask

    task automatic send_bit(input logic b, output logic q);
        logic unused;
        step(1'b0, b, unused);
        step(1'b1, b, q);
        step(1'b0, b, unused);
    endtask

    task automatic do_start();
        logic unused;
        step(1'b0, 1'b1, unused);
        step(1'b1, 1'b1, unused);
        step(1'b1, 1'b0, unused);
        step(1'b0, 1'b0, unused);
    endtask

    task automatic do_stop();
        logic unused;
        step(1'b0, 1'b0, unused);
        step(1'b1, 1'b0, unused);
        step(1'b1, 1'b1, unused);
    endtask

    task automatic ack_cycle(input string req);
        logic q;
        step(1'b0, 1'b1, q);
        step(1'b1, 1'b1, q);
        chk(req, "acknowledge edge drives low", q, 1'b0);
        step(1'b0, 1'b1, q);
        chk("R4", "line released after acknowledge", q, 1'b1);
    endtask

    task automatic idle_pulses(input string req);
        logic q;
        for (int i = 0; i < 9; i++) begin
            send_bit(1'b0, q);
            chk(req, "pulse ignored while idle", q, 1'b1);
        end
    endtask

    task automatic txn(input logic [7:0] c, input logic [7:0] a, input logic [7:0] ex, input string req);
        logic q;
        do_start();
        for (int i = 7; i >= 0; i--) begin
            send_bit(c[i], q);
            chk("R3", "command bit leaves line released", q, 1'b1);
        end
        ack_cycle("R4");
        for (int i = 7; i >= 0; i--) begin
            send_bit(a[i], q);
            chk(req, "address-phase line level", q, c[0] ? ex[i] : 1'b1);
        end
        ack_cycle("R6");
        do_stop();
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic q;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "released after reset", sda_o, 1'b1);

        idle_pulses("R2");

        for (int v = 0; v < 5; v++) begin
            string tag;
            case (VEC[v][1:0])
                2'd1:    tag = "R8";
                2'd2:    tag = "R13";
                default: tag = "R7";
            endcase
            txn(VEC[v][25:18], VEC[v][17:10], VEC[v][9:2], tag);
        end

        // R10: restart after five command bits; data now holds byte 0 = 0x03
        do_start();
        for (int i = 0; i < 5; i++) send_bit(1'b1, q);
        txn(8'hA1, 8'h01, 8'h03, "R10");

        // R5: changed-SDA rising edge is not a bit; data holds byte 1 = 0x0A
        do_start();
        for (int i = 7; i >= 1; i--) send_bit(8'hA1 >> i, q);
        step(1'b0, 1'b0, q);
        step(1'b1, 1'b1, q);
        chk("R5", "unstable rise not acknowledged", q, 1'b1);
        step(1'b0, 1'b1, q);
        send_bit(1'b1, q);
        chk("R5", "eighth counted bit is not the ack slot", q, 1'b1);
        ack_cycle("R5");
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'(8'h02 >> i), q);
            chk("R5", "read data after glitch", q, 1'(8'h0A >> i));
        end
        ack_cycle("R6");
        do_stop();

        // R9: STOP in the middle of the command aborts it
        do_start();
        for (int i = 0; i < 3; i++) send_bit(1'b1, q);
        do_stop();
        idle_pulses("R9");

        // R11: a START shape without strobes does nothing
        @(negedge clk); scl_i = 1'b1; sda_i = 1'b1;
        repeat (2) @(negedge clk); sda_i = 1'b0;
        repeat (2) @(negedge clk); scl_i = 1'b0;
        chk("R11", "no strobe keeps line released", sda_o, 1'b1);
        idle_pulses("R11");

        // R12: reset mid-command; data cleared, image kept (byte 2 = 0x11)
        do_start();
        for (int i = 0; i < 4; i++) send_bit(1'b1, q);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        chk("R12", "released after mid reset", sda_o, 1'b1);
        idle_pulses("R12");
        txn(8'hA1, 8'h02, 8'h00, "R12");
        txn(8'hA1, 8'h00, 8'h11, "R12");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule